// File: doc/BRIEF.md
# Buffered Flash Block Programming Sequencer

This block sits on the host side of a parallel NOR-style flash bus. It takes one block's worth of data from a valid/ready word stream and runs the device's accelerated buffered programming flow on that block. The host supplies a buffer-aligned start address, a word count and a poll limit, then pulses `start_i`. The sequencer sends the setup commands and waits on the device status. It loads the device's write buffer one buffer at a time, waiting for each buffer to finish programming. When the data is done it leaves the accelerated mode, checks the final status and puts the device back in read-array mode.

The bus uses single-cycle strobes. A read strobe returns status on `bus_rdata_i` in the same cycle, and the sequencer decides on that value at the following clock edge. Every run ends with a one-cycle `done_o`. The error flags stay set until the next accepted or rejected start. A final partial buffer is filled with erased-value words, so the device always receives whole buffers while the stream supplies exactly the requested number of words.

Top module: `fbp_seq`

## Requirements
- R1: A start whose address has any of its low log2(BUF_WORDS) bits set, or whose word count is zero, raises `err_param_o` and `done_o` with no bus strobe at all.
- R2: An accepted start issues exactly two writes of 0x0080 to the start address. It then reads status from that same address. Every data write and every status read also targets the start address.
- R3: During setup, a status read with bit 7 clear moves on to programming. A read with bit 7 set and bit 3 set raises `err_vpp_o`, and one with bit 7 set and bit 1 set raises `err_lock_o`. Either of these aborts the run with no data or exit write. Bit 7 set with neither bit keeps polling.
- R4: Before each buffer load, status is read until bit 0 is clear. No data word is written while the device reports bit 0 set.
- R5: A buffer load is exactly BUF_WORDS consecutive data writes. After each load, status is read until bit 0 is clear. If stream words remain, another load follows.
- R6: Stream words are written in arrival order, and exactly `word_cnt_i` of them are taken. The rest of the last buffer is filled with 0xFFFF, and `wready_o` stays low while this filler is written.
- R7: After the last buffer completes, one write of 0xFFFF goes to the start address with address bit BLK_AW inverted. Status is then read until bit 7 is set.
- R8: After the exit completes, one more status read follows. If bit 4 or bit 5 is set, `err_prog_o` is raised and held until the next start.
- R9: The run finishes with a write of 0x00FF to the start address. `done_o` is then high for exactly one cycle and `busy_o` returns low.
- R10: Each status wait tolerates up to `timeout_i` not-ready reads. The next not-ready read raises `err_timeout_o` and ends the run.
- R11: After reset, every strobe, `wready_o`, `busy_o`, `done_o` and every error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a programming run (sampled while idle) |
| start_addr_i | input | AW | First word address, buffer aligned |
| word_cnt_i | input | CW | Number of stream words to program |
| timeout_i | input | TW | Not-ready reads tolerated per status wait |
| wdata_i | input | 16 | Stream data word |
| wvalid_i | input | 1 | Stream word valid |
| wready_o | output | 1 | Stream word taken this cycle when valid |
| bus_addr_o | output | AW | Flash bus address |
| bus_wdata_o | output | 16 | Flash bus write data |
| bus_we_o | output | 1 | Write strobe, one word per cycle |
| bus_re_o | output | 1 | Read strobe, status returned same cycle |
| bus_rdata_i | input | 16 | Flash status read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_param_o | output | 1 | Start rejected: misaligned or zero count |
| err_lock_o | output | 1 | Target block locked |
| err_vpp_o | output | 1 | Programming voltage fault |
| err_timeout_o | output | 1 | A status wait ran out |
| err_prog_o | output | 1 | Final status reported a program fault |

## Verification
The bench builds the sequencer with AW=12, BLK_AW=8, BUF_WORDS=8, CW=8 and TW=6. With an eight-word buffer, counts up to 40 give runs with several refills and partial last buffers that stay short. With 256-word blocks, the exit address sits one bit away from the start address, so a wrong block bit is caught directly. The six-bit poll limit lets the bench place a device's busy time exactly at the limit and one read past it, in the setup wait, the buffer-ready wait and the exit wait. A behavioural device model counts strobes per phase.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int DW = 16;

  localparam int SR_WSM_BIT   = 7;
  localparam int SR_VPP_BIT   = 3;
  localparam int SR_LOCK_BIT  = 1;
  localparam int SR_BUSY_BIT  = 0;
  localparam int SR_PERR0_BIT = 4;
  localparam int SR_PERR1_BIT = 5;

  localparam logic [DW-1:0] CMD_SETUP   = 16'h0080;
  localparam logic [DW-1:0] CMD_EXIT    = 16'hFFFF;
  localparam logic [DW-1:0] CMD_RDARRAY = 16'h00FF;
  localparam logic [DW-1:0] PAD_WORD    = 16'hFFFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP_A,
    ST_SETUP_B,
    ST_POLL_SETUP,
    ST_POLL_RDY,
    ST_LOAD,
    ST_POLL_PROG,
    ST_EXIT_WR,
    ST_POLL_EXIT,
    ST_FULL_CHK,
    ST_RD_ARRAY
  } fbp_state_e;
endpackage

// File: rtl/fbp_poll_timer.sv
module fbp_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          miss_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (miss_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  // the sequencer never records a miss once the limit is reached
  p_miss_below_limit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |-> !expired_o);
endmodule

// File: rtl/fbp_buf_counter.sv
module fbp_buf_counter #(
  parameter int BUF_WORDS = 32,
  parameter int CW        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  input  logic          take_i,
  output logic          slot_last_o,
  output logic          remain_zero_o
);
  localparam int SW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [SW-1:0] slot_q;
  logic [CW-1:0] remain_q;

  assign slot_last_o   = (slot_q == SW'(BUF_WORDS - 1));
  assign remain_zero_o = (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      slot_q   <= '0;
      remain_q <= cnt_i;
    end else begin
      if (step_i) slot_q <= slot_last_o ? '0 : slot_q + 1'b1;
      if (take_i) remain_q <= remain_q - 1'b1;
    end
  end

  p_take_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !remain_zero_o);
  p_take_is_written_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> step_i);
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int AW        = 24,
  parameter int BLK_AW    = 16,
  parameter int BUF_WORDS = 32,
  parameter int CW        = 16,
  parameter int TW        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] word_cnt_i,
  input  logic [TW-1:0] timeout_i,
  input  logic [15:0]   wdata_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [15:0]   bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [15:0]   bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_param_o,
  output logic          err_lock_o,
  output logic          err_vpp_o,
  output logic          err_timeout_o,
  output logic          err_prog_o
);
  localparam int BUFW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam logic [AW-1:0] BLK_FLIP = AW'(1) << BLK_AW;

  fbp_state_e    state_q, state_d;
  logic [AW-1:0] base_q;
  logic [TW-1:0] tmo_q;
  logic          done_q;
  logic          e_param_q, e_lock_q, e_vpp_q, e_tmo_q, e_prog_q;

  logic slot_last, remain_zero, expired;
  logic miss, fin, accept, reject;
  logic set_vpp, set_lock, set_tmo, set_prog;
  logic bad_start;

  assign bad_start = (start_addr_i[BUFW-1:0] != '0) || (word_cnt_i == '0);

  // bus side
  always_comb begin
    bus_addr_o  = base_q;
    bus_wdata_o = '0;
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    unique case (state_q)
      ST_SETUP_A, ST_SETUP_B: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_SETUP;
      end
      ST_LOAD: begin
        bus_we_o    = remain_zero || wvalid_i;
        bus_wdata_o = remain_zero ? PAD_WORD : wdata_i;
      end
      ST_EXIT_WR: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = base_q ^ BLK_FLIP;
        bus_wdata_o = CMD_EXIT;
      end
      ST_RD_ARRAY: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_RDARRAY;
      end
      ST_POLL_SETUP, ST_POLL_RDY, ST_POLL_PROG, ST_POLL_EXIT, ST_FULL_CHK:
        bus_re_o = 1'b1;
      default: ;
    endcase
  end

  assign wready_o = (state_q == ST_LOAD) && !remain_zero;

  // sequencing
  always_comb begin
    state_d  = state_q;
    miss     = 1'b0;
    fin      = 1'b0;
    accept   = 1'b0;
    reject   = 1'b0;
    set_vpp  = 1'b0;
    set_lock = 1'b0;
    set_tmo  = 1'b0;
    set_prog = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (bad_start) begin
          reject = 1'b1;
          fin    = 1'b1;
        end else begin
          accept  = 1'b1;
          state_d = ST_SETUP_A;
        end
      end
      ST_SETUP_A: state_d = ST_SETUP_B;
      ST_SETUP_B: state_d = ST_POLL_SETUP;
      ST_POLL_SETUP: begin
        if (!bus_rdata_i[SR_WSM_BIT]) state_d = ST_POLL_RDY;
        else if (bus_rdata_i[SR_VPP_BIT] || bus_rdata_i[SR_LOCK_BIT]) begin
          set_vpp  = bus_rdata_i[SR_VPP_BIT];
          set_lock = bus_rdata_i[SR_LOCK_BIT];
          fin      = 1'b1;
        end else if (expired) begin
          set_tmo = 1'b1;
          fin     = 1'b1;
        end else miss = 1'b1;
      end
      ST_POLL_RDY: begin
        if (!bus_rdata_i[SR_BUSY_BIT]) state_d = ST_LOAD;
        else if (expired) begin
          set_tmo = 1'b1;
          fin     = 1'b1;
        end else miss = 1'b1;
      end
      ST_LOAD: if (bus_we_o && slot_last) state_d = ST_POLL_PROG;
      ST_POLL_PROG: begin
        if (!bus_rdata_i[SR_BUSY_BIT]) state_d = remain_zero ? ST_EXIT_WR : ST_POLL_RDY;
        else if (expired) begin
          set_tmo = 1'b1;
          fin     = 1'b1;
        end else miss = 1'b1;
      end
      ST_EXIT_WR: state_d = ST_POLL_EXIT;
      ST_POLL_EXIT: begin
        if (bus_rdata_i[SR_WSM_BIT]) state_d = ST_FULL_CHK;
        else if (expired) begin
          set_tmo = 1'b1;
          fin     = 1'b1;
        end else miss = 1'b1;
      end
      ST_FULL_CHK: begin
        set_prog = bus_rdata_i[SR_PERR0_BIT] || bus_rdata_i[SR_PERR1_BIT];
        state_d  = ST_RD_ARRAY;
      end
      ST_RD_ARRAY: fin = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      tmo_q     <= '0;
      done_q    <= 1'b0;
      e_param_q <= 1'b0;
      e_lock_q  <= 1'b0;
      e_vpp_q   <= 1'b0;
      e_tmo_q   <= 1'b0;
      e_prog_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept) begin
        base_q <= start_addr_i;
        tmo_q  <= timeout_i;
      end
      if (accept || reject) begin
        e_param_q <= reject;
        e_lock_q  <= 1'b0;
        e_vpp_q   <= 1'b0;
        e_tmo_q   <= 1'b0;
        e_prog_q  <= 1'b0;
      end else begin
        if (set_lock) e_lock_q <= 1'b1;
        if (set_vpp)  e_vpp_q  <= 1'b1;
        if (set_tmo)  e_tmo_q  <= 1'b1;
        if (set_prog) e_prog_q <= 1'b1;
      end
    end
  end

  fbp_poll_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_d != state_q),
    .miss_i    (miss),
    .limit_i   (tmo_q),
    .expired_o (expired)
  );

  fbp_buf_counter #(.BUF_WORDS(BUF_WORDS), .CW(CW)) u_bufcnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (accept),
    .cnt_i         (word_cnt_i),
    .step_i        ((state_q == ST_LOAD) && bus_we_o),
    .take_i        (wvalid_i && wready_o),
    .slot_last_o   (slot_last),
    .remain_zero_o (remain_zero)
  );

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_param_o   = e_param_q;
  assign err_lock_o    = e_lock_q;
  assign err_vpp_o     = e_vpp_q;
  assign err_timeout_o = e_tmo_q;
  assign err_prog_o    = e_prog_q;

  p_reject_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && bad_start) |=>
      (!bus_we_o && !bus_re_o && done_o && err_param_o));
  p_first_poll_after_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL_SETUP && $rose(bus_re_o)) |->
      ($past(bus_we_o) && $past(bus_wdata_o) == CMD_SETUP));
  p_load_after_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && $past(state_q) == ST_POLL_RDY) |->
      !$past(bus_rdata_i[SR_BUSY_BIT]));
  p_exit_outside_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == CMD_EXIT && bus_addr_o != base_q) |->
      (bus_addr_o[AW-1:BLK_AW] != base_q[AW-1:BLK_AW]));
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_strobe_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
endmodule

// File: tb/fbp_seq_bench.sv
`timescale 1ns/1ps
module fbp_seq_bench;
  localparam int AW = 12, BLK_AW = 8, BUF = 8, CW = 8, TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] word_cnt_i = '0;
  logic [TW-1:0] timeout_i = '0;
  logic [15:0]   wdata_i = '0;
  logic          wvalid_i = 1'b0;
  logic          wready_o;
  logic [AW-1:0] bus_addr_o;
  logic [15:0]   bus_wdata_o;
  logic          bus_we_o, bus_re_o;
  logic [15:0]   bus_rdata_i;
  logic          busy_o, done_o, err_param_o, err_lock_o, err_vpp_o, err_timeout_o, err_prog_o;

  fbp_seq #(.AW(AW), .BLK_AW(BLK_AW), .BUF_WORDS(BUF), .CW(CW), .TW(TW)) u_fbp_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .word_cnt_i(word_cnt_i), .timeout_i(timeout_i), .wdata_i(wdata_i), .wvalid_i(wvalid_i),
    .wready_o(wready_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_param_o(err_param_o), .err_lock_o(err_lock_o),
    .err_vpp_o(err_vpp_o), .err_timeout_o(err_timeout_o), .err_prog_o(err_prog_o)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // job configuration shared with the device model and stream driver
  logic [AW-1:0] job_addr = '0;
  int  job_cnt = 0;
  int  cfg_sb = 0, cfg_rb = 0, cfg_pb = 0, cfg_eb = 0, cfg_perr = 0;
  bit  cfg_lock = 0, cfg_vpp = 0;
  bit  m_clr = 0;
  logic [15:0] words [64];

  // device model
  int m_phase, m_n80, m_ndata, m_exit_n, m_ff_n, m_bad, m_badaddr, m_strobes;
  int m_sl, m_busy, m_el, idx;
  logic [15:0] got [64];

  function automatic logic [AW-1:0] exit_addr_of(input logic [AW-1:0] a);
    return a ^ (AW'(1) << BLK_AW);
  endfunction

  always_comb begin
    bus_rdata_i = '0;
    case (m_phase)
      1: begin
        bus_rdata_i[7] = (m_sl != 0) || cfg_lock || cfg_vpp;
        bus_rdata_i[3] = cfg_vpp;
        bus_rdata_i[1] = cfg_lock;
      end
      2: bus_rdata_i[0] = (m_busy != 0);
      3: begin
        bus_rdata_i[7] = (m_el == 0);
        bus_rdata_i[4] = cfg_perr[0];
        bus_rdata_i[5] = cfg_perr[1];
      end
      default: ;
    endcase
  end

  always @(posedge clk) begin
    if (m_clr) begin
      m_phase <= 0; m_n80 <= 0; m_ndata <= 0; m_exit_n <= 0; m_ff_n <= 0;
      m_bad <= 0; m_badaddr <= 0; m_strobes <= 0;
      m_sl <= cfg_sb; m_busy <= 0; m_el <= 0; idx <= 0;
    end else begin
      if (wvalid_i && wready_o) idx <= idx + 1;
      if (bus_we_o || bus_re_o) m_strobes <= m_strobes + 1;
      if (bus_we_o) begin
        if (bus_addr_o == exit_addr_of(job_addr) && bus_wdata_o == 16'hFFFF) begin
          m_exit_n <= m_exit_n + 1;
          m_phase  <= 3;
          m_el     <= cfg_eb;
          if (m_phase != 2) m_bad <= m_bad + 1;
        end else if (bus_addr_o != job_addr) m_badaddr <= m_badaddr + 1;
        else case (m_phase)
          0: if (bus_wdata_o == 16'h0080) begin
               m_n80 <= m_n80 + 1;
               if (m_n80 == 1) m_phase <= 1;
             end else m_bad <= m_bad + 1;
          2: begin
               if (m_busy != 0) m_bad <= m_bad + 1;
               if (m_ndata < 64) got[m_ndata] <= bus_wdata_o;
               m_ndata <= m_ndata + 1;
               if ((m_ndata + 1) % BUF == 0) m_busy <= cfg_pb;
             end
          3: if (bus_wdata_o == 16'h00FF) begin
               m_ff_n  <= m_ff_n + 1;
               m_phase <= 0;
             end else m_bad <= m_bad + 1;
          default: m_bad <= m_bad + 1;
        endcase
      end
      if (bus_re_o) begin
        if (bus_addr_o != job_addr) m_badaddr <= m_badaddr + 1;
        case (m_phase)
          1: if (m_sl != 0) m_sl <= m_sl - 1;
             else if (!cfg_lock && !cfg_vpp) begin m_phase <= 2; m_busy <= cfg_rb; end
          2: if (m_busy != 0) m_busy <= m_busy - 1;
          3: if (m_el != 0) m_el <= m_el - 1;
          default: m_bad <= m_bad + 1;
        endcase
      end
    end
  end

  // stream driver
  initial begin
    forever begin
      @(negedge clk);
      wvalid_i = (idx < job_cnt) && ($urandom_range(0, 3) != 0);
      wdata_i  = words[(idx < 64) ? idx : 0];
    end
  end

  // kind: 0 ok, 1 param, 2 lock, 3 vpp, 4 timeout
  task automatic run_job(input string nm, input logic [AW-1:0] addr, input int cnt, input int tmo,
                         input int sb, input bit lock, input bit vpp, input int rb, input int pb,
                         input int eb, input int perr, input int kind);
    int n, exp_n, mism;
    @(negedge clk);
    job_addr = addr; job_cnt = cnt; cfg_sb = sb; cfg_lock = lock; cfg_vpp = vpp;
    cfg_rb = rb; cfg_pb = pb; cfg_eb = eb; cfg_perr = perr;
    for (int i = 0; i < 64; i++) words[i] = 16'($urandom);
    m_clr = 1;
    @(negedge clk);
    m_clr = 0;
    start_i = 1; start_addr_i = addr; word_cnt_i = CW'(cnt); timeout_i = TW'(tmo);
    @(negedge clk);
    start_i = 0;
    n = 0;
    while (!done_o && n < 4000) begin @(negedge clk); n++; end
    chk(done_o == 1, {nm, " R9 done seen"}, done_o, 1);
    chk(err_param_o == (kind == 1), {nm, " R1 err_param"}, err_param_o, kind == 1);
    chk(err_lock_o == lock, {nm, " R3 err_lock"}, err_lock_o, lock);
    chk(err_vpp_o == vpp, {nm, " R3 err_vpp"}, err_vpp_o, vpp);
    chk(err_timeout_o == (kind == 4), {nm, " R10 err_timeout"}, err_timeout_o, kind == 4);
    if (kind == 1)
      chk(m_strobes == 0, {nm, " R1 no bus strobes"}, m_strobes, 0);
    if (kind == 2 || kind == 3) begin
      chk(m_n80 == 2, {nm, " R2 setup writes"}, m_n80, 2);
      chk(m_ndata == 0 && m_exit_n == 0, {nm, " R3 abort before data"}, m_ndata + m_exit_n, 0);
    end
    if (kind == 0) begin
      exp_n = ((cnt + BUF - 1) / BUF) * BUF;
      mism = 0;
      for (int i = 0; i < exp_n && i < 64; i++)
        if (got[i] !== ((i < cnt) ? words[i] : 16'hFFFF)) mism++;
      chk(m_n80 == 2, {nm, " R2 setup writes"}, m_n80, 2);
      chk(m_badaddr == 0, {nm, " R2 address use"}, m_badaddr, 0);
      chk(m_bad == 0, {nm, " R4 writes only when ready"}, m_bad, 0);
      chk(m_ndata == exp_n, {nm, " R5 whole buffers"}, m_ndata, exp_n);
      chk(mism == 0, {nm, " R6 data order and padding"}, mism, 0);
      chk(idx == cnt, {nm, " R6 stream words taken"}, idx, cnt);
      chk(m_exit_n == 1, {nm, " R7 exit write"}, m_exit_n, 1);
      chk(err_prog_o == (perr != 0), {nm, " R8 err_prog"}, err_prog_o, perr != 0);
      chk(m_ff_n == 1, {nm, " R9 read array write"}, m_ff_n, 1);
    end
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, {nm, " R9 single done pulse"}, done_o + busy_o, 0);
    chk(wready_o == 0, {nm, " R6 no ready when idle"}, wready_o, 0);
    if (kind == 0)
      chk(err_prog_o == (perr != 0), {nm, " R8 sticky err_prog"}, err_prog_o, perr != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_clr = 1;
    repeat (3) @(negedge clk);
    chk({bus_we_o, bus_re_o, wready_o, busy_o, done_o} == 0, "R11 reset strobes", 1, 0);
    chk({err_param_o, err_lock_o, err_vpp_o, err_timeout_o, err_prog_o} == 0, "R11 reset errors", 1, 0);
    rst_n = 1;
    @(negedge clk);
    m_clr = 0;
    chk({bus_we_o, bus_re_o, busy_o} == 0, "R11 idle after reset", 1, 0);

    run_job("misaligned",  12'h104, 8,  3, 0, 0, 0, 0, 0, 0, 0, 1);
    run_job("zero_count",  12'h100, 0,  3, 0, 0, 0, 0, 0, 0, 0, 1);
    run_job("locked",      12'h200, 8,  3, 1, 1, 0, 0, 0, 0, 0, 2);
    run_job("vpp_fault",   12'h300, 8,  3, 0, 0, 1, 0, 0, 0, 0, 3);
    run_job("tmo_edge_ok", 12'h040, 8,  4, 4, 0, 0, 4, 4, 4, 0, 0);
    run_job("tmo_setup",   12'h040, 8,  4, 5, 0, 0, 0, 0, 0, 0, 4);
    run_job("tmo_ready",   12'h080, 8,  2, 0, 0, 0, 3, 0, 0, 0, 4);
    run_job("tmo_prog",    12'h080, 16, 2, 0, 0, 0, 0, 3, 0, 0, 4);
    run_job("tmo_exit",    12'h0C0, 8,  2, 0, 0, 0, 0, 0, 3, 0, 4);
    run_job("one_word",    12'h008, 1,  0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_job("exact_bufs",  12'h510, 24, 3, 1, 0, 0, 2, 3, 1, 1, 0);
    run_job("prog_err_b5", 12'h520, 13, 3, 2, 0, 0, 1, 1, 2, 2, 0);
    run_job("clean_after", 12'h520, 9,  3, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 10; k++) begin
      int c = $urandom_range(1, 40);
      int t = $urandom_range(0, 5);
      run_job("random", {4'($urandom), 5'($urandom), 3'b000}, c, t,
              $urandom_range(0, t), 0, 0, $urandom_range(0, t), $urandom_range(0, t),
              $urandom_range(0, t), $urandom_range(0, 3), 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule